// File: doc/BRIEF.md
# Converter Startup and Reset Sequencer

This block sits on the host side of a delta-sigma converter. It brings the converter from an unknown state to a state where data can be read. A start request launches a fixed sequence. First, the block drives the converter's active-low reset pin low for a set number of cycles. It then waits for a hold-off interval, whose length depends on why the sequence was started. If power was removed, the converter runs an internal reset of 2^POR_LOG2 master clock cycles. The sequencer waits out that interval plus a margin chosen at run time, so that the supplies can settle. If power stayed on, the block only needs a short post-reset wait.

If the serial clock may have floated, the block then cleans up the serial interface. It holds SCLK low while it counts a fixed number of data-ready falling edges. After that it asks the external SPI shifter for a register readback. It compares the returned byte with a known identity value that is neither all zeros nor all ones. If the byte matches, the block waits for the next data-ready falling edge and then reports ready. A mismatch, or a data-ready line that stays silent for too long, ends the sequence with a fault.

The block sequences and times the bring-up only. Shifting the readback byte and capturing conversion data are left to the logic around it.

Top module: `adc_boot_seq`

## Requirements
- R1: After reset the outputs are: reset pin high, SCLK hold low, readback request low, ready low, fault low, busy low.
- R2: A start request seen while idle, ready or faulted drives the reset pin low for exactly RST_LOW cycles.
- R3: When the power-removed flag is 1 at start, exactly 2^POR_LOG2 + margin cycles pass from reset pin release to the next phase. The margin is the value of the margin input at start.
- R4: When the power-removed flag is 0 at start, that interval is exactly SHORT_WAIT cycles, whatever the margin input holds.
- R5: When the clean-up flag is 1 at start, SCLK hold is asserted after the wait. It is released only after SPI_PERIODS data-ready falling edges (1 to 0 transitions of the active-low line). No readback is requested while it is held.
- R6: The readback request stays high until the done strobe. A returned byte equal to ID_VALUE lets the sequence continue. Any other byte sets fault and returns the block to idle with busy low.
- R7: After a matching readback, ready rises only after a data-ready falling edge. If no edge arrives within DRDY_TMO cycles, fault is set and the block goes idle.
- R8: During the SCLK hold, a gap of DRDY_TMO cycles without a data-ready falling edge sets fault and ends the hold.
- R9: A start request while busy is ignored: the reset pin is not pulsed again and the current wait length is unchanged.
- R10: Ready and fault are never high together, and both read 0 from the first cycle of a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock that all intervals count |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a bring-up sequence |
| pwr_cut_i | input | 1 | Power was removed before this start; sampled at start |
| clean_i | input | 1 | Perform the serial-clock hold clean-up; sampled at start |
| margin_i | input | MARGIN_W | Extra settle cycles after a power cut; sampled at start |
| drdy_n_i | input | 1 | Converter data-ready line, active low, asynchronous |
| rb_done_i | input | 1 | Strobe from the shifter: readback byte is valid |
| rb_data_i | input | DW | Byte returned by the readback |
| adc_rst_n_o | output | 1 | Converter reset pin, active low |
| sclk_hold_o | output | 1 | Force the serial clock low |
| rb_req_o | output | 1 | Request a register readback |
| busy_o | output | 1 | Sequence in progress |
| ready_o | output | 1 | Converter confirmed alive and data ready |
| fault_o | output | 1 | Sequence ended on mismatch or timeout |

## Verification
The bench sweeps every margin value with the power-removed flag both set and clear. A design that added the margin without a power cut, or that was off by one cycle in either wait, would return the wrong interval. The bench counts data-ready edges during the SCLK hold and checks that the hold is still asserted after the 63rd edge. A counter that ended one edge early would release the hold too soon. The bench also drives a wrong identity byte, silent data-ready lines in both waiting phases, and a start request in the middle of a wait. A design that declared ready on a bad byte, hung without a timeout, or restarted on the extra request would show a wrong status or a wrong interval.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_SCLK,
    ST_READ,
    ST_DRDY,
    ST_READY
  } seq_st_e;
endpackage

// File: rtl/adc_boot_fall.sv
module adc_boot_fall #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], line_n_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/adc_boot_timer.sv
module adc_boot_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  input  logic          dec_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                      cnt_d = val_i;
    else if (dec_i && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/adc_boot_seq.sv
module adc_boot_seq
  import adc_boot_pkg::*;
#(
  parameter int          POR_LOG2    = 16,
  parameter int          MARGIN_W    = 12,
  parameter int          RST_LOW     = 8,
  parameter int          SHORT_WAIT  = 4,
  parameter int          SPI_PERIODS = 64,
  parameter int          DRDY_TMO    = 400000,
  parameter int          DW          = 8,
  parameter logic [DW-1:0] ID_VALUE  = 8'hA5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                pwr_cut_i,
  input  logic                clean_i,
  input  logic [MARGIN_W-1:0] margin_i,
  input  logic                drdy_n_i,
  input  logic                rb_done_i,
  input  logic [DW-1:0]       rb_data_i,
  output logic                adc_rst_n_o,
  output logic                sclk_hold_o,
  output logic                rb_req_o,
  output logic                busy_o,
  output logic                ready_o,
  output logic                fault_o
);
  localparam int LONG_MAX = (1 << POR_LOG2) + (1 << MARGIN_W);
  localparam int BIG1     = (LONG_MAX > DRDY_TMO) ? LONG_MAX : DRDY_TMO;
  localparam int BIG2     = (BIG1 > RST_LOW) ? BIG1 : RST_LOW;
  localparam int BIG3     = (BIG2 > SHORT_WAIT) ? BIG2 : SHORT_WAIT;
  localparam int CW       = $clog2(BIG3 + 1);
  localparam int EW       = $clog2(SPI_PERIODS + 1);

  seq_st_e st_q, st_d;
  logic    pwr_q, clean_q, fault_q;
  logic [MARGIN_W-1:0] margin_q;
  logic [EW-1:0] edge_q;

  logic          t_load, t_dec, t_zero;
  logic [CW-1:0] t_val;
  logic          cfg_ld, fault_set, edge_clr, edge_inc;
  logic          drdy_fall;
  logic [CW-1:0] wait_m1;

  adc_boot_fall #(.STAGES(2)) u_fall (
    .clk(clk), .rst_n(rst_n), .line_n_i(drdy_n_i), .fall_o(drdy_fall)
  );

  adc_boot_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val),
    .dec_i(t_dec), .zero_o(t_zero)
  );

  // hold-off length depends on the cause captured at start
  assign wait_m1 = pwr_q ? (CW'(1 << POR_LOG2) + CW'(margin_q) - 1'b1)
                         : CW'(SHORT_WAIT - 1);

  always_comb begin
    st_d      = st_q;
    t_load    = 1'b0;
    t_val     = '0;
    t_dec     = 1'b0;
    cfg_ld    = 1'b0;
    fault_set = 1'b0;
    edge_clr  = 1'b0;
    edge_inc  = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_READY: begin
        if (start_i) begin
          st_d   = ST_PULSE;
          cfg_ld = 1'b1;
          t_load = 1'b1;
          t_val  = CW'(RST_LOW - 1);
        end
      end
      ST_PULSE: begin
        if (t_zero) begin
          st_d   = ST_WAIT;
          t_load = 1'b1;
          t_val  = wait_m1;
        end else t_dec = 1'b1;
      end
      ST_WAIT: begin
        if (t_zero) begin
          if (clean_q) begin
            st_d     = ST_SCLK;
            t_load   = 1'b1;
            t_val    = CW'(DRDY_TMO - 1);
            edge_clr = 1'b1;
          end else st_d = ST_READ;
        end else t_dec = 1'b1;
      end
      ST_SCLK: begin
        if (drdy_fall) begin
          if (edge_q == EW'(SPI_PERIODS - 1)) st_d = ST_READ;
          else begin
            edge_inc = 1'b1;
            t_load   = 1'b1;
            t_val    = CW'(DRDY_TMO - 1);
          end
        end else if (t_zero) begin
          st_d      = ST_IDLE;
          fault_set = 1'b1;
        end else t_dec = 1'b1;
      end
      ST_READ: begin
        if (rb_done_i) begin
          if (rb_data_i == ID_VALUE) begin
            st_d   = ST_DRDY;
            t_load = 1'b1;
            t_val  = CW'(DRDY_TMO - 1);
          end else begin
            st_d      = ST_IDLE;
            fault_set = 1'b1;
          end
        end
      end
      ST_DRDY: begin
        if (drdy_fall) st_d = ST_READY;
        else if (t_zero) begin
          st_d      = ST_IDLE;
          fault_set = 1'b1;
        end else t_dec = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      pwr_q    <= 1'b0;
      clean_q  <= 1'b0;
      margin_q <= '0;
      fault_q  <= 1'b0;
      edge_q   <= '0;
    end else begin
      st_q <= st_d;
      if (cfg_ld) begin
        pwr_q    <= pwr_cut_i;
        clean_q  <= clean_i;
        margin_q <= margin_i;
      end
      if (cfg_ld)         fault_q <= 1'b0;
      else if (fault_set) fault_q <= 1'b1;
      if (edge_clr)       edge_q <= '0;
      else if (edge_inc)  edge_q <= edge_q + 1'b1;
    end
  end

  assign adc_rst_n_o = (st_q != ST_PULSE);
  assign sclk_hold_o = (st_q == ST_SCLK);
  assign rb_req_o    = (st_q == ST_READ);
  assign ready_o     = (st_q == ST_READY);
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_READY);
  assign fault_o     = fault_q;
endmodule

// File: rtl/adc_boot_chk.sv
module adc_boot_chk (
  input logic clk,
  input logic rst_n,
  input logic drdy_fall,
  input logic rb_done_i,
  input logic adc_rst_n_o,
  input logic sclk_hold_o,
  input logic rb_req_o,
  input logic busy_o,
  input logic ready_o,
  input logic fault_o
);
  assert_pin_low_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_rst_n_o |-> busy_o);

  assert_hold_blocks_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_hold_o |-> !rb_req_o);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_req_o && !rb_done_i) |=> rb_req_o);

  assert_req_drop_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rb_req_o) |-> $past(rb_done_i));

  assert_ready_needs_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(drdy_fall));

  assert_no_repulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && adc_rst_n_o) |=> adc_rst_n_o);

  assert_status_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready_o && fault_o));
endmodule

bind adc_boot_seq adc_boot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drdy_fall(drdy_fall), .rb_done_i(rb_done_i),
  .adc_rst_n_o(adc_rst_n_o), .sclk_hold_o(sclk_hold_o), .rb_req_o(rb_req_o),
  .busy_o(busy_o), .ready_o(ready_o), .fault_o(fault_o)
);

// File: tb/tb_adc_boot_seq.sv
module tb_adc_boot_seq;
  localparam int POR_LOG2 = 5;
  localparam int MW       = 3;
  localparam int RLOW     = 3;
  localparam int SWAIT    = 4;
  localparam int NPER     = 64;
  localparam int TMO      = 40;
  localparam logic [7:0] IDV = 8'hA5;

  logic clk, rst_n, start_i, pwr_cut_i, clean_i, drdy_n_i, rb_done_i;
  logic [MW-1:0] margin_i;
  logic [7:0] rb_data_i;
  logic adc_rst_n_o, sclk_hold_o, rb_req_o, busy_o, ready_o, fault_o;
  int n_chk, n_bad;

  adc_boot_seq #(
    .POR_LOG2(POR_LOG2), .MARGIN_W(MW), .RST_LOW(RLOW), .SHORT_WAIT(SWAIT),
    .SPI_PERIODS(NPER), .DRDY_TMO(TMO), .DW(8), .ID_VALUE(IDV)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pwr_cut_i(pwr_cut_i),
    .clean_i(clean_i), .margin_i(margin_i), .drdy_n_i(drdy_n_i),
    .rb_done_i(rb_done_i), .rb_data_i(rb_data_i), .adc_rst_n_o(adc_rst_n_o),
    .sclk_hold_o(sclk_hold_o), .rb_req_o(rb_req_o), .busy_o(busy_o),
    .ready_o(ready_o), .fault_o(fault_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run(input bit pwr, input bit cln, input int m,
                     input logic [7:0] data, input bit give_fall, input bit poke);
    int lowcnt, w, c, expw;
    bit repulse;
    pwr_cut_i = pwr; clean_i = cln; margin_i = MW'(m);
    step(); start_i = 1'b1; step(); start_i = 1'b0;
    chk(!fault_o && !ready_o, "R10", {fault_o, ready_o}, 0);
    lowcnt = 0;
    while (!adc_rst_n_o && lowcnt < 100) begin lowcnt++; step(); end
    chk(lowcnt == RLOW, "R2", lowcnt, RLOW);
    w = 0; repulse = 0;
    while (busy_o && !rb_req_o && !sclk_hold_o && w < 1000) begin
      if (!adc_rst_n_o) repulse = 1;
      start_i = (poke && w == 1);
      w++; step();
    end
    start_i = 1'b0;
    expw = pwr ? (1 << POR_LOG2) + m : SWAIT;
    chk(w == expw, pwr ? "R3" : "R4", w, expw);
    if (poke) chk(!repulse, "R9", repulse, 0);
    if (cln) begin
      chk(sclk_hold_o && !rb_req_o, "R5", sclk_hold_o, 1);
      if (!give_fall) begin
        c = 0;
        while (sclk_hold_o && c < 1000) begin c++; step(); end
        chk(c == TMO, "R8", c, TMO);
        chk(fault_o && !busy_o, "R8", fault_o, 1);
        return;
      end
      for (int k = 0; k < NPER; k++) begin
        drdy_n_i = 1'b0; step(2); drdy_n_i = 1'b1; step(2);
        if (k == NPER - 2) begin
          step(6);
          chk(sclk_hold_o && !rb_req_o, "R5", sclk_hold_o, 1);
        end
      end
      step(6);
      chk(!sclk_hold_o && rb_req_o, "R5", rb_req_o, 1);
    end
    chk(rb_req_o, "R6", rb_req_o, 1);
    step(2);
    chk(rb_req_o, "R6", rb_req_o, 1);
    rb_data_i = data; rb_done_i = 1'b1; step(); rb_done_i = 1'b0;
    if (data != IDV) begin
      chk(!busy_o && fault_o && !ready_o, "R6", fault_o, 1);
      return;
    end
    if (give_fall) begin
      step(3);
      chk(!ready_o && busy_o, "R7", ready_o, 0);
      drdy_n_i = 1'b0; step(5); drdy_n_i = 1'b1;
      chk(ready_o && !fault_o && !busy_o, "R7", ready_o, 1);
      step(2);
    end else begin
      c = 0;
      while (busy_o && c < 1000) begin c++; step(); end
      chk(c == TMO, "R7", c, TMO);
      chk(fault_o && !ready_o, "R7", fault_o, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start_i = 1'b0; pwr_cut_i = 1'b0; clean_i = 1'b0;
    margin_i = '0; drdy_n_i = 1'b1; rb_done_i = 1'b0; rb_data_i = '0;
    step(3);
    chk(adc_rst_n_o && !sclk_hold_o && !rb_req_o && !busy_o && !ready_o && !fault_o,
        "R1", {adc_rst_n_o, sclk_hold_o, rb_req_o, busy_o, ready_o, fault_o}, 6'b100000);
    rst_n = 1'b1;
    step(3);
    chk(adc_rst_n_o && !busy_o && !ready_o && !fault_o, "R1", busy_o, 0);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < (1 << MW); m++)
        run(p[0], 1'b0, m, IDV, 1'b1, (m == 3));
    run(1'b1, 1'b1, 5, IDV, 1'b1, 1'b0);
    run(1'b0, 1'b1, 0, IDV, 1'b0, 1'b0);
    run(1'b0, 1'b0, 2, 8'h5A, 1'b0, 1'b0);
    run(1'b0, 1'b0, 7, IDV, 1'b0, 1'b0);
    run(1'b0, 1'b0, 1, IDV, 1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule